// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block is the control core on the device side of a serial NOR flash. It never sees the serial lines. A front end that has already deserialized each command hands it a command record: the opcode, the 24-bit address, the first data byte and the number of bits clocked while the device was selected. The record is qualified by a one-cycle strobe that marks the rising edge of chip select. The block also watches the write-protect pin and a power-on indication.

The block holds the status byte. From that byte, the pin and its own timers it decides whether each completed command is accepted or refused. Accepted program and erase commands go out to the array as a strobe carrying a kind code and an address. The block then holds the busy flag for a self-timed interval whose length depends on the operation.

Every completed command yields exactly one accept or reject pulse, so each decision is visible at the ports.

Top module: `flash_wp_ctrl`

## Requirements
- R1: The status byte is laid out as {SRP, 0, TB, BP2, BP1, BP0, WEL, WIP}, with WIP at bit 0, WEL at bit 1, BP0..BP2 at bits 2..4, TB at bit 5 and SRP at bit 7. Reset clears every bit.
- R2: Opcode 06h sets WEL and opcode 04h clears it. Program (02h), erase (20h, 52h, D8h, C7h, 60h) and status write (01h) are refused while WEL is 0. A refused command leaves WEL unchanged.
- R3: A program needs a bit count that is a multiple of 8 and at least 40. A sector or block erase needs a multiple of 8 and at least 32. A chip erase needs a multiple of 8. A status write needs exactly 16 or 24 bits in total. Any other count drops the command.
- R4: The protected range is decoded as follows. If BP1 is 1, all 64 KB are protected. If BP1 is 0 and BP0 is 1, the upper half (address bit 15 = 1) is protected when TB is 0, and the lower half when TB is 1. If BP1 and BP0 are both 0, nothing is protected. Program, sector erase and 32 KB erase aimed at a protected address are refused. A 64 KB erase is refused if any range is protected.
- R5: A chip erase (C7h or 60h) is refused whenever BP1 or BP0 is 1.
- R6: When SRP is 1 and wp_n is low, a status write is refused and the status byte is left unchanged.
- R7: For T_PUW cycles after reset or a power-on pulse, write enable, program, erase and status write are refused.
- R8: An accepted operation holds WIP at 1 for exactly its own cycle count: T_PP for program, T_SE for sector erase, T_BE for either block erase, T_CE for chip erase and T_SW for status write. WIP and WEL clear together at the end. A status write loads BP, TB and SRP from data bits 4:2, 5 and 7 only when it finishes.
- R9: While WIP is 1, every command except 05h is refused, including reads and write enable.
- R10: After an accepted power-down (B9h), every command except ABh is refused, including 05h. ABh leaves power-down.
- R11: Each command strobe yields, one cycle later, exactly one of acc or rej, each lasting one cycle. An accepted program or erase also pulses op_go in that same cycle, with op_kind (0 program, 1 sector, 2 block 32 KB, 3 block 64 KB, 4 chip) and op_addr.
- R12: A power-on pulse clears WEL, WIP and power-down and restarts the inhibit window. It keeps BP, TB and SRP, and the command strobe in that cycle gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| por | input | 1 | Power-on indication pulse |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_end | input | 1 | One-cycle strobe at chip-select release |
| cmd_op | input | 8 | Opcode of the completed command |
| cmd_addr | input | 24 | Address received with the command |
| cmd_bits | input | BITS_W | Total bits clocked, opcode included |
| cmd_data | input | 8 | First data byte (status write value) |
| status | output | 8 | Status byte |
| acc | output | 1 | Command accepted pulse |
| rej | output | 1 | Command refused pulse |
| op_go | output | 1 | Array operation strobe |
| op_kind | output | 3 | Kind of array operation |
| op_addr | output | 24 | Address of array operation |

## Verification
The hardest state to reach is the moment when several gates overlap. Examples are a status write while SRP is set and the pin is low, or a write enable that arrives inside a busy interval or during the power-up window. A table of command vectors walks the status byte through a chain of protection settings, so that each later row is judged against the BP, TB and SRP values that an earlier accepted status write installed. Directed sequences then issue commands while the busy timer is running, while the device is powered down and right after a power-on pulse. They also count the busy cycles of a program one by one.

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
  parameter int T_PP   = 20,
  parameter int T_SE   = 40,
  parameter int T_BE   = 60,
  parameter int T_CE   = 120,
  parameter int T_SW   = 30,
  parameter int T_PUW  = 50,
  parameter int BITS_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por,
  input  logic              wp_n,
  input  logic              cmd_end,
  input  logic [7:0]        cmd_op,
  input  logic [23:0]       cmd_addr,
  input  logic [BITS_W-1:0] cmd_bits,
  input  logic [7:0]        cmd_data,
  output logic [7:0]        status,
  output logic              acc,
  output logic              rej,
  output logic              op_go,
  output logic [2:0]        op_kind,
  output logic [23:0]       op_addr
);
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TMAX = imax(imax(imax(T_PP, T_SE), imax(T_BE, T_CE)), T_SW);
  localparam int CW   = imax(1, $clog2(TMAX + 1));
  localparam int IW   = imax(1, $clog2(T_PUW + 1));

  logic          wip, wel, tb, srp, pd, sw_go;
  logic [2:0]    bp;
  logic [7:0]    sw_pend;
  logic [CW-1:0] busy_cnt;
  logic [IW-1:0] inh_cnt;

  assign status = {srp, 1'b0, tb, bp, wel, wip};

  wire inhibit   = inh_cnt != '0;
  wire byte_ok   = cmd_bits[2:0] == 3'd0;
  wire any_prot  = bp[1] | bp[0];
  wire addr_prot = bp[1] | (bp[0] & (tb ? ~cmd_addr[15] : cmd_addr[15]));
  wire wr_ok     = wel & ~inhibit;
  wire locked    = srp & ~wp_n;

  logic          ok, is_mem, is_sw;
  logic [2:0]    kind;
  logic [CW-1:0] dur;

  always_comb begin
    ok = 1'b0; is_mem = 1'b0; is_sw = 1'b0; kind = 3'd0; dur = '0;
    case (cmd_op)
      8'h05, 8'h03, 8'h0B, 8'h3B, 8'hBB, 8'h4B, 8'h90, 8'h9F,
      8'hAB, 8'hB9, 8'h04: ok = 1'b1;
      8'h06: ok = ~inhibit;
      8'h01: begin
        is_sw = 1'b1; dur = CW'(T_SW - 1);
        ok = wr_ok & ~locked & (cmd_bits == BITS_W'(16) || cmd_bits == BITS_W'(24));
      end
      8'h02: begin
        is_mem = 1'b1; kind = 3'd0; dur = CW'(T_PP - 1);
        ok = wr_ok & byte_ok & (cmd_bits >= BITS_W'(40)) & ~addr_prot;
      end
      8'h20, 8'h52: begin
        is_mem = 1'b1; kind = (cmd_op == 8'h20) ? 3'd1 : 3'd2;
        dur = (cmd_op == 8'h20) ? CW'(T_SE - 1) : CW'(T_BE - 1);
        ok = wr_ok & byte_ok & (cmd_bits >= BITS_W'(32)) & ~addr_prot;
      end
      8'hD8: begin
        is_mem = 1'b1; kind = 3'd3; dur = CW'(T_BE - 1);
        ok = wr_ok & byte_ok & (cmd_bits >= BITS_W'(32)) & ~any_prot;
      end
      8'hC7, 8'h60: begin
        is_mem = 1'b1; kind = 3'd4; dur = CW'(T_CE - 1);
        ok = wr_ok & byte_ok & (cmd_bits >= BITS_W'(8)) & ~any_prot;
      end
      default: ok = 1'b0;
    endcase
    if (pd)       ok = (cmd_op == 8'hAB);
    else if (wip) ok = (cmd_op == 8'h05);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip <= 1'b0; wel <= 1'b0; tb <= 1'b0; srp <= 1'b0; pd <= 1'b0;
      bp <= '0; sw_go <= 1'b0; sw_pend <= '0; busy_cnt <= '0;
      inh_cnt <= IW'(T_PUW);
      acc <= 1'b0; rej <= 1'b0; op_go <= 1'b0; op_kind <= '0; op_addr <= '0;
    end else begin
      acc <= 1'b0; rej <= 1'b0; op_go <= 1'b0;
      if (por) begin
        wip <= 1'b0; wel <= 1'b0; pd <= 1'b0; sw_go <= 1'b0;
        busy_cnt <= '0; inh_cnt <= IW'(T_PUW);
      end else begin
        if (inhibit) inh_cnt <= inh_cnt - 1'b1;
        if (wip) begin
          if (busy_cnt == '0) begin
            wip <= 1'b0; wel <= 1'b0; sw_go <= 1'b0;
            if (sw_go) begin
              bp <= sw_pend[4:2]; tb <= sw_pend[5]; srp <= sw_pend[7];
            end
          end else busy_cnt <= busy_cnt - 1'b1;
        end
        if (cmd_end) begin
          acc <= ok; rej <= ~ok;
          if (ok) begin
            case (cmd_op)
              8'h06: wel <= 1'b1;
              8'h04: wel <= 1'b0;
              8'hB9: pd  <= 1'b1;
              8'hAB: pd  <= 1'b0;
              default: ;
            endcase
            if (is_mem | is_sw) begin
              wip <= 1'b1; busy_cnt <= dur;
            end
            if (is_sw) begin
              sw_go <= 1'b1; sw_pend <= cmd_data;
            end
            if (is_mem) begin
              op_go <= 1'b1; op_kind <= kind; op_addr <= cmd_addr;
            end
          end
        end
      end
    end
  end

  // R11
  acc_rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && rej));
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> acc);
  // R8
  busy_end_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);
  // R2
  go_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_go |-> $past(wel));
  // R9
  no_go_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wip) |-> !op_go);
  // R10
  no_go_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pd) |-> !op_go);
endmodule

// File: tb/sim_flash_wp_ctrl.sv
module sim_flash_wp_ctrl;
  localparam int T_PP = 20, T_SE = 40, T_BE = 60, T_CE = 120, T_SW = 30, T_PUW = 50;

  logic clk = 1'b0, rst_n = 1'b0, por = 1'b0, wp_n = 1'b1, cmd_end = 1'b0;
  logic [7:0] cmd_op = '0, cmd_data = '0;
  logic [23:0] cmd_addr = '0;
  logic [11:0] cmd_bits = '0;
  logic [7:0] status;
  logic acc, rej, op_go;
  logic [2:0] op_kind;
  logic [23:0] op_addr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_wp_ctrl #(.T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE), .T_CE(T_CE),
                  .T_SW(T_SW), .T_PUW(T_PUW), .BITS_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .por(por), .wp_n(wp_n), .cmd_end(cmd_end),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_bits(cmd_bits),
    .cmd_data(cmd_data), .status(status), .acc(acc), .rej(rej),
    .op_go(op_go), .op_kind(op_kind), .op_addr(op_addr));

  // {op, addr, bits, data, wp_n, expect_acc, expect_status}
  typedef logic [57:0] vec_t;
  localparam int NV = 29;
  localparam vec_t VT [NV] = '{
    {8'h06, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b1, 8'h02}, // R2 set WEL
    {8'h02, 24'h000100, 8'd40, 8'h00, 1'b1, 1'b1, 8'h00}, // R8 program clears WEL
    {8'h02, 24'h000100, 8'd40, 8'h00, 1'b1, 1'b0, 8'h00}, // R2 no WEL
    {8'h06, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b1, 8'h02},
    {8'h02, 24'h000100, 8'd41, 8'h00, 1'b1, 1'b0, 8'h02}, // R3 off boundary
    {8'h01, 24'h000000, 8'd16, 8'h04, 1'b1, 1'b1, 8'h04}, // R8 BP0 set
    {8'h06, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b1, 8'h06},
    {8'h02, 24'h008000, 8'd40, 8'h00, 1'b1, 1'b0, 8'h06}, // R4 upper protected
    {8'h02, 24'h000010, 8'd40, 8'h00, 1'b1, 1'b1, 8'h04}, // R4 lower free
    {8'h06, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b1, 8'h06},
    {8'hC7, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b0, 8'h06}, // R5
    {8'h01, 24'h000000, 8'd24, 8'h24, 1'b1, 1'b1, 8'h24}, // R3 24 bits, TB=1
    {8'h06, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b1, 8'h26},
    {8'h20, 24'h001000, 8'd32, 8'h00, 1'b1, 1'b0, 8'h26}, // R4 lower protected
    {8'h52, 24'h008000, 8'd32, 8'h00, 1'b1, 1'b1, 8'h24}, // R4 upper free
    {8'h06, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b1, 8'h26},
    {8'h01, 24'h000000, 8'd20, 8'h00, 1'b1, 1'b0, 8'h26}, // R3 bad length
    {8'h01, 24'h000000, 8'd16, 8'h80, 1'b1, 1'b1, 8'h80}, // SRP set
    {8'h06, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b1, 8'h82},
    {8'h01, 24'h000000, 8'd16, 8'h00, 1'b0, 1'b0, 8'h82}, // R6 locked
    {8'h01, 24'h000000, 8'd16, 8'h00, 1'b1, 1'b1, 8'h00}, // R6 pin high
    {8'h06, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b1, 8'h02},
    {8'hC7, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b1, 8'h00}, // R5 unprotected
    {8'h5A, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b0, 8'h00}, // unknown opcode
    {8'h06, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b1, 8'h02},
    {8'h04, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b1, 8'h00}, // R2 clear WEL
    {8'hD8, 24'h000000, 8'd32, 8'h00, 1'b1, 1'b0, 8'h00}, // R2
    {8'h06, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b1, 8'h02},
    {8'h60, 24'h000000, 8'd8,  8'h00, 1'b1, 1'b1, 8'h00}  // R5 alt opcode
  };

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] op, input logic [23:0] ad,
                     input logic [11:0] nb, input logic [7:0] d,
                     output logic a, output logic r);
    @(negedge clk);
    cmd_op = op; cmd_addr = ad; cmd_bits = nb; cmd_data = d; cmd_end = 1'b1;
    @(negedge clk);
    cmd_end = 1'b0;
    a = acc; r = rej;
  endtask

  task automatic wait_idle();
    while (status[0]) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, r;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'h00, "R1 reset status", status, 0);
    cmd(8'h06, 0, 8, 0, a, r);
    chk(!a && r, "R7 WREN in inhibit", a, 0);
    chk(status[1] == 1'b0, "R7 WEL stays 0", status, 0);
    @(negedge clk);
    chk(!acc && !rej, "R11 single pulse", {acc, rej}, 0);
    repeat (T_PUW + 4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VT[i];
      wp_n = v[9];
      cmd(v[57:50], v[49:26], {4'd0, v[25:18]}, v[17:10], a, r);
      chk(a == v[8] && r == !v[8], $sformatf("R11 vec %0d accept", i), a, v[8]);
      wait_idle();
      chk(status == v[7:0], $sformatf("R8 vec %0d status", i), status, v[7:0]);
    end
    wp_n = 1'b1;

    // R8 busy count and R11 strobe fields
    cmd(8'h06, 0, 8, 0, a, r);
    cmd(8'h02, 24'h000200, 40, 0, a, r);
    chk(a && op_go && op_kind == 3'd0 && op_addr == 24'h000200, "R11 program strobe",
        {op_kind, op_addr}, 24'h000200);
    cnt = 1;
    while (status[0]) begin
      @(negedge clk);
      if (status[0]) cnt++;
    end
    chk(cnt == T_PP, "R8 program busy cycles", cnt, T_PP);
    chk(status == 8'h00, "R8 WIP and WEL clear", status, 0);

    // R9 commands during busy
    cmd(8'h06, 0, 8, 0, a, r);
    cmd(8'h20, 24'h003000, 32, 0, a, r);
    chk(a && op_go && op_kind == 3'd1, "R11 sector strobe", op_kind, 1);
    cmd(8'h05, 0, 16, 0, a, r);
    chk(a, "R9 status read while busy", a, 1);
    cmd(8'h03, 0, 40, 0, a, r);
    chk(!a && r, "R9 read refused while busy", a, 0);
    cmd(8'h06, 0, 8, 0, a, r);
    chk(!a && r, "R9 WREN refused while busy", a, 0);
    wait_idle();
    chk(status == 8'h00, "R9 end of erase", status, 0);

    // R10 power-down
    cmd(8'hB9, 0, 8, 0, a, r);
    chk(a, "R10 enter power-down", a, 1);
    cmd(8'h05, 0, 16, 0, a, r);
    chk(!a && r, "R10 status read refused", a, 0);
    cmd(8'h06, 0, 8, 0, a, r);
    chk(!a && status[1] == 1'b0, "R10 WREN refused", status, 0);
    cmd(8'hAB, 0, 32, 0, a, r);
    chk(a, "R10 release", a, 1);
    cmd(8'h05, 0, 16, 0, a, r);
    chk(a, "R10 status read after release", a, 1);

    // R12 power-on pulse
    cmd(8'h06, 0, 8, 0, a, r);
    cmd(8'h01, 0, 16, 8'h08, a, r);
    wait_idle();
    chk(status == 8'h08, "R12 BP1 installed", status, 8'h08);
    cmd(8'h06, 0, 8, 0, a, r);
    @(negedge clk);
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
    chk(status == 8'h08, "R12 WEL cleared BP kept", status, 8'h08);
    cmd(8'h06, 0, 8, 0, a, r);
    chk(!a && r, "R12 inhibit restarted", a, 0);
    repeat (T_PUW + 4) @(negedge clk);
    cmd(8'h06, 0, 8, 0, a, r);
    chk(a && status == 8'h0A, "R12 WREN after window", status, 8'h0A);
    cmd(8'hD8, 24'h000000, 32, 0, a, r);
    chk(!a && !op_go, "R4 64KB erase with BP1", a, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule